// File: doc/BRIEF.md
# Interrupt Line Concentrator

This block collects 160 level-sensitive peripheral interrupt lines and merges them onto three processor-facing outputs. Each raw line first passes through a two-flop synchroniser. It then meets a per-line enable bit and a per-line software force bit. The resulting pending bit is `(synchronised line AND enable) OR force`. Pending bits are level-sensitive, so a pending bit falls again as soon as its cause goes away.

The pending bits fall into three unequal output groups. Group 0 covers lines 31:0. Group 1 covers lines 95:32. Group 2 covers lines 159:96. Each group ORs its pending bits onto one output, and a per-group quiet bit can hold that output low. After reset every line is disabled, no line is forced and every group is quiet, so nothing fires until software opens the path.

Software reaches the block through a word-addressed, single-cycle port. Writes are registered on the clock edge. Reads are combinational from the current address. Per-line control and pending words are indexed from the top down: word 0 holds the highest lines. Software can also read each group's pending bits relative to the group's lowest line, together with each group's line count.

Top module: `irqmux_top`

## Requirements
- R1: After a synchronous reset, every enable word and every force word reads 0 and the quiet register at address 0x18 reads 7. All three outputs are low.
- R2: A change on a raw line reaches its pending bit after exactly two rising clock edges, and not after one.
- R3: The pending words at addresses 0x10+k (k = 0..4) are indexed from the top down. Bit b of word k is line 32*(4-k)+b, so word 0 holds lines 159:128 and word 4 holds lines 31:0.
- R4: The pending bit of a line equals (synchronised line AND its enable bit) OR its force bit. A disabled line therefore stays low, and a forced line is high whatever its input does.
- R5: Output m goes high exactly when some pending bit in its range is high and its quiet bit is clear. The ranges are lines 31:0 for m=0, 95:32 for m=1 and 159:96 for m=2.
- R6: Quiet bit m is bit m of the word at address 0x18. While it is 1, output m stays low. Writes of bits [2:0] take effect on the next edge.
- R7: Address 0x20+2m returns relative pending bits 31:0 of group m, and 0x21+2m returns relative bits 63:32. Relative bit 0 is the group's lowest line, so line 34 is bit 2 at address 0x22. Bits beyond a group's size read 0.
- R8: Addresses 0x28, 0x29 and 0x2A return the line counts 32, 64 and 64.
- R9: Writes to read-only or unused addresses change nothing, and reads of unused addresses return 0.
- R10: Enable words sit at 0x00+k and force words at 0x08+k, with the same top-down line mapping as R3. Each word reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 160 | Raw peripheral interrupt lines, bit n is line n |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | 6 | Word address shared by reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| master_irq | output | 3 | Group outputs, bit m is group m |

## Verification
The assertions take for granted that the raw lines are sampled only on rising clock edges. They also assume that the address and write strobe hold still between edges, and that the reset lasts at least one edge before any check counts cycles. The bench changes every input shortly after a falling edge and keeps it steady through the next rising edge. It holds reset over several edges, and it draws random lines, addresses and write data only within the 6-bit address space. In that way the two-edge delay and the quiet gating are observed under the same sampling assumptions the properties use.

// File: rtl/irqmux_pkg.sv
// Package: shared constants and helpers for the interrupt line concentrator.
// Assumes 32-bit words and a fixed word-address map; spans are multiples of 32.
package irqmux_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned ADDR_W     = 6;

    localparam int unsigned MASK_BASE  = 32'h00;
    localparam int unsigned FORCE_BASE = 32'h08;
    localparam int unsigned STAT_BASE  = 32'h10;
    localparam int unsigned QUIET_ADDR = 32'h18;
    localparam int unsigned MSTAT_BASE = 32'h20;
    localparam int unsigned MCNT_BASE  = 32'h28;

    // Lowest system line owned by group m.
    function automatic int unsigned group_base(int unsigned m, int unsigned first,
                                               int unsigned span);
        return (m == 0) ? 0 : first + span * (m - 1);
    endfunction

    // Number of lines owned by group m.
    function automatic int unsigned group_span(int unsigned m, int unsigned first,
                                               int unsigned span);
        return (m == 0) ? first : span;
    endfunction

endpackage

// File: rtl/irqmux_sync.sv
// Module: two-flop synchroniser for a vector of raw interrupt lines.
// Assumes each line is a slow level; no bus coherency across bits is implied.
module irqmux_sync #(
    parameter int unsigned WIDTH = 160
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage1;

    // Capture then re-time the raw lines; reset clears both stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/irqmux_regs.sv
// Module: software-writable enable, force and quiet registers.
// Assumes word addressing; word k controls lines from the top down.
module irqmux_regs
    import irqmux_pkg::*;
#(
    parameter int unsigned NUM_WORDS   = 5,
    parameter int unsigned NUM_MASTERS = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [DATA_W-1:0]                  wr_data,
    output logic [NUM_WORDS-1:0][DATA_W-1:0]   mask_w,
    output logic [NUM_WORDS-1:0][DATA_W-1:0]   force_w,
    output logic [NUM_MASTERS-1:0]             quiet
);

    logic [31:0] addr_ext;
    assign addr_ext = 32'(addr);

    // Update enable and force words; reset leaves every line closed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_w  <= '0;
            force_w <= '0;
        end else if (wr_en) begin
            for (int unsigned k = 0; k < NUM_WORDS; k++) begin
                if (addr_ext == MASK_BASE + k)  mask_w[k]  <= wr_data;
                if (addr_ext == FORCE_BASE + k) force_w[k] <= wr_data;
            end
        end
    end

    // Update the per-group quiet bits; reset silences every group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet <= '1;
        end else if (wr_en && addr_ext == QUIET_ADDR) begin
            quiet <= wr_data[NUM_MASTERS-1:0];
        end
    end

endmodule

// File: rtl/irqmux_master.sv
// Module: one output group; ORs a slice of pending bits and gates it.
// Assumes BASE+SPAN fits inside NUM_LINES and SPAN <= PAD.
module irqmux_master #(
    parameter int unsigned NUM_LINES = 160,
    parameter int unsigned BASE      = 0,
    parameter int unsigned SPAN      = 32,
    parameter int unsigned PAD       = 64
) (
    input  logic [NUM_LINES-1:0] pend_line,
    input  logic                 quiet,
    output logic [PAD-1:0]       rel_pend,
    output logic                 irq_o
);

    logic [SPAN-1:0] slice;
    assign slice = pend_line[BASE +: SPAN];

    // Place the slice at relative bit 0, zero-padding a short group.
    generate
        if (SPAN == PAD) begin : g_full
            assign rel_pend = slice;
        end else begin : g_pad
            assign rel_pend = {{(PAD - SPAN){1'b0}}, slice};
        end
    endgenerate

    // Any pending bit in range raises the output unless the group is quiet.
    assign irq_o = (|slice) & ~quiet;

endmodule

// File: rtl/irqmux_top.sv
// Module: interrupt line concentrator top; synchronises, enables, forces,
// groups and gates the lines, and serves the register read port.
// Assumes FIRST_SPAN and SPAN are multiples of 32 and the map fits 6 address bits.
module irqmux_top
    import irqmux_pkg::*;
#(
    parameter int unsigned FIRST_SPAN  = 32,
    parameter int unsigned SPAN        = 64,
    parameter int unsigned NUM_MASTERS = 3,
    localparam int unsigned NUM_LINES  = FIRST_SPAN + SPAN * (NUM_MASTERS - 1),
    localparam int unsigned NUM_WORDS  = NUM_LINES / DATA_W,
    localparam int unsigned PAD        = (FIRST_SPAN > SPAN) ? FIRST_SPAN : SPAN,
    localparam int unsigned MSW        = PAD / DATA_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LINES-1:0]   irq_in,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wr_data,
    output logic [DATA_W-1:0]      rd_data,
    output logic [NUM_MASTERS-1:0] master_irq
);

    logic [NUM_LINES-1:0]             sync_line;
    logic [NUM_LINES-1:0]             mask_line;
    logic [NUM_LINES-1:0]             force_line;
    logic [NUM_LINES-1:0]             pend_line;
    logic [NUM_WORDS-1:0][DATA_W-1:0] mask_w;
    logic [NUM_WORDS-1:0][DATA_W-1:0] force_w;
    logic [NUM_WORDS-1:0][DATA_W-1:0] pend_w;
    logic [NUM_MASTERS-1:0]           quiet;
    logic [NUM_MASTERS-1:0][PAD-1:0]  rel_pend;
    logic [31:0]                      addr_ext;

    assign addr_ext = 32'(addr);

    irqmux_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_in),
        .q     (sync_line)
    );

    irqmux_regs #(.NUM_WORDS(NUM_WORDS), .NUM_MASTERS(NUM_MASTERS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .mask_w  (mask_w),
        .force_w (force_w),
        .quiet   (quiet)
    );

    // Word k maps to the k-th highest block of lines.
    generate
        for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
            localparam int unsigned LO = DATA_W * (NUM_WORDS - 1 - k);
            assign mask_line[LO +: DATA_W]  = mask_w[k];
            assign force_line[LO +: DATA_W] = force_w[k];
            assign pend_w[k]                = pend_line[LO +: DATA_W];
        end
    endgenerate

    // Level-sensitive pending bit: enabled input or software force.
    assign pend_line = (sync_line & mask_line) | force_line;

    generate
        for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_master
            irqmux_master #(
                .NUM_LINES (NUM_LINES),
                .BASE      (group_base(m, FIRST_SPAN, SPAN)),
                .SPAN      (group_span(m, FIRST_SPAN, SPAN)),
                .PAD       (PAD)
            ) u_master (
                .pend_line (pend_line),
                .quiet     (quiet[m]),
                .rel_pend  (rel_pend[m]),
                .irq_o     (master_irq[m])
            );
        end
    endgenerate

    // Decode the word address into read data; unmatched addresses give zero.
    always_comb begin
        rd_data = '0;
        for (int unsigned k = 0; k < NUM_WORDS; k++) begin
            if (addr_ext == MASK_BASE + k)  rd_data = mask_w[k];
            if (addr_ext == FORCE_BASE + k) rd_data = force_w[k];
            if (addr_ext == STAT_BASE + k)  rd_data = pend_w[k];
        end
        if (addr_ext == QUIET_ADDR) rd_data = {{(DATA_W - NUM_MASTERS){1'b0}}, quiet};
        for (int unsigned m = 0; m < NUM_MASTERS; m++) begin
            for (int unsigned h = 0; h < MSW; h++) begin
                if (addr_ext == MSTAT_BASE + m * MSW + h)
                    rd_data = rel_pend[m][DATA_W * h +: DATA_W];
            end
            if (addr_ext == MCNT_BASE + m)
                rd_data = DATA_W'(group_span(m, FIRST_SPAN, SPAN));
        end
    end

endmodule

// File: rtl/irqmux_chk.sv
// Module: property checker for the interrupt line concentrator, bound to the top.
// Assumes inputs change only between rising edges.
module irqmux_chk
    import irqmux_pkg::*;
#(
    parameter int unsigned FIRST_SPAN  = 32,
    parameter int unsigned SPAN        = 64,
    parameter int unsigned NUM_MASTERS = 3,
    parameter int unsigned NUM_LINES   = 160
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_LINES-1:0]   irq_in,
    input logic [NUM_LINES-1:0]   sync_line,
    input logic [NUM_LINES-1:0]   force_line,
    input logic [NUM_LINES-1:0]   pend_line,
    input logic [NUM_MASTERS-1:0] quiet,
    input logic [NUM_MASTERS-1:0] master_irq,
    input logic [ADDR_W-1:0]      addr,
    input logic [DATA_W-1:0]      rd_data
);

    logic [1:0] live_cyc;

    // Count edges since reset, saturating, to guard the two-edge lookback.
    always_ff @(posedge clk) begin
        if (!rst_n) live_cyc <= '0;
        else if (live_cyc != 2'd3) live_cyc <= live_cyc + 2'd1;
    end

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (master_irq == '0 && quiet == '1));

    a_r2_two_edge_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cyc >= 2'd2) |-> (sync_line == $past(irq_in, 2)));

    a_r4_force_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (force_line & ~pend_line) == '0);

    a_r6_quiet_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (master_irq & quiet) == '0);

    a_r8_first_count: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(addr) == MCNT_BASE) |-> (rd_data == DATA_W'(FIRST_SPAN)));

    generate
        for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_grp
            localparam int unsigned B = group_base(m, FIRST_SPAN, SPAN);
            localparam int unsigned S = group_span(m, FIRST_SPAN, SPAN);
            a_r5_pending_raises: assert property (@(posedge clk) disable iff (!rst_n)
                ((|pend_line[B +: S]) && !quiet[m]) |-> master_irq[m]);
            a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
                !(|pend_line[B +: S]) |-> !master_irq[m]);
        end
    endgenerate

endmodule

bind irqmux_top irqmux_chk #(
    .FIRST_SPAN  (FIRST_SPAN),
    .SPAN        (SPAN),
    .NUM_MASTERS (NUM_MASTERS),
    .NUM_LINES   (NUM_LINES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .sync_line  (sync_line),
    .force_line (force_line),
    .pend_line  (pend_line),
    .quiet      (quiet),
    .master_irq (master_irq),
    .addr       (addr),
    .rd_data    (rd_data)
);

// File: tb/irqmux_top_bench.sv
// Bench: behavioural reference model compared on every falling edge,
// plus directed checks per requirement.
module irqmux_top_bench;

    localparam int PERIOD = 10;
    localparam int NL     = 160;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] irq_in = '0;
    logic          wr_en = 1'b0;
    logic [5:0]    addr = '0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic [2:0]    master_irq;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  compare_on = 1'b0;

    // Reference state.
    bit [31:0]   r_mask [5];
    bit [31:0]   r_force[5];
    bit [2:0]    r_quiet = 3'b111;
    bit [NL-1:0] hist[$];

    irqmux_top u_irqmux_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .wr_en      (wr_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .master_irq (master_irq)
    );

    always #(PERIOD / 2) clk = ~clk;

    // Model update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            hist.push_back('0);
            hist.push_back('0);
            for (int k = 0; k < 5; k++) begin
                r_mask[k]  = '0;
                r_force[k] = '0;
            end
            r_quiet = 3'b111;
        end else begin
            hist.push_front(irq_in);
            void'(hist.pop_back());
            if (wr_en) begin
                if (addr < 5) r_mask[addr] = wr_data;
                else if (addr >= 8 && addr < 13) r_force[addr - 8] = wr_data;
                else if (addr == 6'h18) r_quiet = wr_data[2:0];
            end
        end
    end

    function automatic bit line_pend(int l);
        int w = 4 - l / 32;
        return (hist[1][l] & r_mask[w][l % 32]) | r_force[w][l % 32];
    endfunction

    function automatic int gbase(int m);
        return (m == 0) ? 0 : 32 + 64 * (m - 1);
    endfunction

    function automatic int gsize(int m);
        return (m == 0) ? 32 : 64;
    endfunction

    function automatic bit [2:0] exp_master();
        bit [2:0] r = '0;
        for (int m = 0; m < 3; m++) begin
            bit any = 1'b0;
            for (int i = 0; i < gsize(m); i++) any |= line_pend(gbase(m) + i);
            r[m] = any & ~r_quiet[m];
        end
        return r;
    endfunction

    function automatic bit [31:0] exp_read(int a);
        bit [31:0] r = '0;
        if (a < 5) r = r_mask[a];
        else if (a >= 8 && a < 13) r = r_force[a - 8];
        else if (a >= 16 && a < 21) begin
            for (int b = 0; b < 32; b++) r[b] = line_pend(32 * (4 - (a - 16)) + b);
        end else if (a == 24) r = {29'b0, r_quiet};
        else if (a >= 32 && a < 38) begin
            int m = (a - 32) / 2;
            int h = (a - 32) % 2;
            for (int b = 0; b < 32; b++)
                if (32 * h + b < gsize(m)) r[b] = line_pend(gbase(m) + 32 * h + b);
        end else if (a >= 40 && a < 43) r = gsize(a - 40);
        return r;
    endfunction

    function automatic string req_of(int a);
        if (a < 5 || (a >= 8 && a < 13)) return "R10";
        if (a >= 16 && a < 21) return "R3";
        if (a == 24) return "R6";
        if (a >= 32 && a < 38) return "R7";
        if (a >= 40 && a < 43) return "R8";
        return "R9";
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (compare_on && rst_n) begin
            check(master_irq == exp_master(), "R5", 32'(master_irq), 32'(exp_master()));
            check(rd_data == exp_read(int'(addr)), req_of(int'(addr)),
                  rd_data, exp_read(int'(addr)));
        end
    end

    task automatic wr(int a, bit [31:0] d);
        @(negedge clk); #1;
        addr = 6'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_expect(int a, bit [31:0] e, string req);
        @(negedge clk); #1;
        addr = 6'(a);
        #2;
        check(rd_data == e, req, rd_data, e);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(PERIOD * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        compare_on = 1'b1;

        // R1: reset values
        rd_expect(6'h18, 32'd7, "R1");
        rd_expect(6'h00, 32'd0, "R1");
        rd_expect(6'h0C, 32'd0, "R1");
        #1 check(master_irq == 3'b000, "R1", 32'(master_irq), 32'd0);

        // R8: counts
        rd_expect(6'h28, 32'd32, "R8");
        rd_expect(6'h29, 32'd64, "R8");
        rd_expect(6'h2A, 32'd64, "R8");

        // R10: enable word 4 covers lines 31:0; readback
        wr(6'h04, 32'hFFFF_FFFF);
        rd_expect(6'h04, 32'hFFFF_FFFF, "R10");
        wr(6'h18, 32'd0);
        rd_expect(6'h18, 32'd0, "R6");

        // R2: two-edge latency on line 3
        @(negedge clk); #1;
        irq_in[3] = 1'b1; addr = 6'h14;
        @(negedge clk); #2;
        check(rd_data == 32'd0, "R2", rd_data, 32'd0);
        @(negedge clk); #2;
        check(rd_data == 32'h8, "R2", rd_data, 32'h8);
        check(master_irq == 3'b001, "R5", 32'(master_irq), 32'd1);

        // R4: disabled line stays low (line 34 raw, word 3 still 0)
        @(negedge clk); #1 irq_in[34] = 1'b1;
        repeat (3) @(negedge clk);
        rd_expect(6'h22, 32'd0, "R4");
        // R7: enable line 34 -> group 1 relative bit 2
        wr(6'h03, 32'h4);
        rd_expect(6'h22, 32'h4, "R7");
        #1 check(master_irq == 3'b011, "R5", 32'(master_irq), 32'd3);

        // R6: quiet group 1 only
        wr(6'h18, 32'h2);
        #1 check(master_irq == 3'b001, "R6", 32'(master_irq), 32'd1);

        // R4: force line 69 (word 2 bit 5) -> group 1 relative bit 37
        wr(6'h18, 32'h0);
        wr(6'h0A, 32'h20);
        rd_expect(6'h23, 32'h20, "R4");
        rd_expect(6'h12, 32'h20, "R3");

        // R3: line 159 via force word 0 bit 31
        wr(6'h08, 32'h8000_0000);
        rd_expect(6'h10, 32'h8000_0000, "R3");
        rd_expect(6'h25, 32'h8000_0000, "R7");
        rd_expect(6'h21, 32'd0, "R7");

        // R9: writes to read-only/unused addresses are ignored
        wr(6'h10, 32'h0);
        wr(6'h28, 32'h5);
        wr(6'h3F, 32'hFFFF_FFFF);
        rd_expect(6'h10, 32'h8000_0000, "R9");
        rd_expect(6'h28, 32'd32, "R9");
        rd_expect(6'h3F, 32'd0, "R9");
        rd_expect(6'h05, 32'd0, "R9");

        // Random phase, model compared on every cycle.
        for (int i = 0; i < 600; i++) begin
            @(negedge clk); #1;
            irq_in  = {$urandom, $urandom, $urandom, $urandom, $urandom};
            addr    = 6'($urandom_range(0, 63));
            wr_data = $urandom;
            wr_en   = ($urandom_range(0, 3) == 0);
        end
        @(negedge clk); #1 wr_en = 1'b0;

        // R1: reset again mid-run
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1 rst_n = 1'b1;
        rd_expect(6'h18, 32'd7, "R1");
        rd_expect(6'h08, 32'd0, "R1");
        #1 check(master_irq == 3'b000, "R1", 32'(master_irq), 32'd0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule